// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit timer/counter peripheral for a small microcontroller core. It advances on either of two sources. In timer operation it counts machine-cycle strobes, where one machine cycle is twelve oscillator periods. In event operation it counts falling transitions on an external count pin, and that pin is sampled once per machine cycle. Software reaches a control byte, the two count bytes and a 16-bit reload/capture pair through a byte-wide register port.

The block has three modes:

- **Capture mode.** The counter runs freely and wraps through zero. A falling edge on the trigger pin latches the live count into the reload/capture pair.
- **Auto-reload mode.** Overflow reloads the counter from the pair. In this mode the counter can also count down, and the trigger pin level then selects the direction.
- **Baud mode.** Overflow reloads the counter silently and emits a one-clock tick for a serial shifter.

Top module: `evt_timer16`

## Requirements
- R1: Register map by `addr`: 0 control, 1 count low byte, 2 count high byte, 3 reload/capture low byte, 4 reload/capture high byte, 5 read-only status (bit 0 = direction toggle bit). Any other address reads 0 and ignores writes. Control bits:
  - 7 = overflow flag
  - 6 = trigger flag
  - 5 = baud mode
  - 4 = down-count enable
  - 3 = trigger enable
  - 2 = run
  - 1 = event select
  - 0 = capture mode
- R2: After reset every register reads 0, and `ovf_flag`, `ext_flag` and `baud_tick` are low.
- R3: With run=1 and event select=0, the count increments by one on each clock where `cyc_en` is high, and holds otherwise.
- R4: With event select=1, the count increments only on a `cyc_en` cycle where `ext_cnt` is 0 and its sample from the previous `cyc_en` cycle was 1.
- R5: In capture mode (bit0=1, bit5=0) the counter counts up. On a step from 0xFFFF it goes to 0x0000 and sets the overflow flag.
- R6: In capture mode with trigger enable set, a 1-to-0 change of `ext_trig` copies the count into the reload/capture pair and sets the trigger flag. With trigger enable clear, the change does nothing.
- R7: In auto-reload mode (bit0=0, bit5=0), a step from 0xFFFF while counting up loads the reload value and sets the overflow flag.
- R8: With down-count enable set in auto-reload mode, the counter counts down while `ext_trig`=0 and up while it is 1. A down step from 0x0000 loads the reload value and sets the overflow flag. Any wrap in this mode toggles the status direction bit.
- R9: In baud mode (bit5=1), a step from 0xFFFF loads the reload value and leaves the overflow flag unchanged. `baud_tick` is high for exactly the one clock following that wrap.
- R10: Hardware never clears the overflow or trigger flags; only a write to the control register changes them.
- R11: A write to a count byte in the same cycle as a count step wins, and the step is lost. A write to the control register in the same cycle as a flag-setting event wins.
- R12: With run=0 the count does not change, whatever `cyc_en` and `ext_cnt` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | One-clock strobe per machine cycle |
| ext_cnt | input | 1 | External event input |
| ext_trig | input | 1 | Capture trigger / count direction input |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ovf_flag | output | 1 | Overflow flag (control bit 7) |
| ext_flag | output | 1 | Trigger flag (control bit 6) |
| baud_tick | output | 1 | One-clock pulse after a baud-mode wrap |

## Verification
The assertions assume `cyc_en` is a single-clock strobe, that inputs change only between clock edges, and that a control write is the only intended way to change the flags. The stimulus drives every input on the falling clock edge. It raises `cyc_en` for one clock at a time, never toggles `ext_cnt` or `ext_trig` within a clock, and presets the count with `cyc_en` low. Every wrap and capture in the run is therefore caused deliberately.

// File: rtl/evt_timer16.sv
`timescale 1ns/1ps
module evt_timer16 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       ext_cnt,
  input  logic       ext_trig,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       ovf_flag,
  output logic       ext_flag,
  output logic       baud_tick
);
  localparam logic [15:0] TOP = 16'hFFFF;

  logic [15:0] cnt, rld, cnt_nx;
  logic [7:0]  ctl;
  logic        dirq, ev_q, tr_q, tick;

  wire baud  = ctl[5];
  wire dn_en = ctl[4];
  wire tren  = ctl[3];
  wire run   = ctl[2];
  wire evsel = ctl[1];
  wire capm  = ctl[0] & ~baud;
  wire arl   = ~baud & ~ctl[0];

  wire ctl_wr = we && addr == 3'd0;
  wire lo_wr  = we && addr == 3'd1;
  wire hi_wr  = we && addr == 3'd2;
  wire cnt_wr = lo_wr | hi_wr;

  wire ev_fall   = cyc_en & ev_q & ~ext_cnt;
  wire step      = run & (evsel ? ev_fall : cyc_en) & ~cnt_wr;
  wire down      = arl & dn_en & ~ext_trig;
  wire wrap      = step & (down ? (cnt == 16'd0) : (cnt == TOP));
  wire trig_fall = tr_q & ~ext_trig;
  wire cap_hit   = capm & tren & trig_fall;

  always_comb begin
    if (wrap)      cnt_nx = capm ? 16'd0 : rld;
    else if (down) cnt_nx = cnt - 16'd1;
    else           cnt_nx = cnt + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rld  <= '0;
      ctl  <= '0;
      dirq <= 1'b0;
      ev_q <= 1'b1;
      tr_q <= 1'b1;
      tick <= 1'b0;
    end else begin
      tr_q <= ext_trig;
      if (cyc_en) ev_q <= ext_cnt;
      tick <= wrap & baud;

      if (lo_wr)      cnt[7:0]  <= wdata;
      else if (hi_wr) cnt[15:8] <= wdata;
      else if (step)  cnt       <= cnt_nx;

      if (we && addr == 3'd3)      rld[7:0]  <= wdata;
      else if (we && addr == 3'd4) rld[15:8] <= wdata;
      else if (cap_hit)            rld       <= cnt;

      if (ctl_wr) ctl <= wdata;
      else begin
        if (wrap & ~baud) ctl[7] <= 1'b1;
        if (cap_hit)      ctl[6] <= 1'b1;
      end

      if (wrap & arl & dn_en) dirq <= ~dirq;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = ctl;
      3'd1:    rdata = cnt[7:0];
      3'd2:    rdata = cnt[15:8];
      3'd3:    rdata = rld[7:0];
      3'd4:    rdata = rld[15:8];
      3'd5:    rdata = {7'd0, dirq};
      default: rdata = 8'd0;
    endcase
  end

  assign ovf_flag  = ctl[7];
  assign ext_flag  = ctl[6];
  assign baud_tick = tick;
endmodule

// File: rtl/evt_timer16_chk.sv
`timescale 1ns/1ps
module evt_timer16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic        ovf_flag,
  input logic        ext_flag,
  input logic        baud_tick,
  input logic [7:0]  ctl,
  input logic [15:0] cnt
);
  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(we && addr == 3'd0)) |=> ovf_flag);

  // R10
  exf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flag && !(we && addr == 3'd0)) |=> ext_flag);

  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  // R9
  tick_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(baud_tick) |-> $past(ctl[5]));

  // R12
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[2] && !(we && (addr == 3'd1 || addr == 3'd2))) |=> $stable(cnt));

  // R11
  lo_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 3'd1) |=> cnt[7:0] == $past(wdata));
endmodule

bind evt_timer16 evt_timer16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .ovf_flag(ovf_flag), .ext_flag(ext_flag), .baud_tick(baud_tick),
  .ctl(ctl), .cnt(cnt)
);

// File: tb/evt_timer16_tb.sv
`timescale 1ns/1ps
module evt_timer16_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_en = 1'b0, ext_cnt = 1'b0, ext_trig = 1'b1, we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic ovf_flag, ext_flag, baud_tick;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_timer16 u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_cnt(ext_cnt),
    .ext_trig(ext_trig), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .baud_tick(baud_tick)
  );

  // {addr, write data, expected read}
  localparam logic [18:0] VEC [8] = '{
    {3'd3, 8'h5A, 8'h5A}, {3'd4, 8'hA5, 8'hA5},
    {3'd1, 8'h34, 8'h34}, {3'd2, 8'h12, 8'h12},
    {3'd0, 8'hC8, 8'hC8}, {3'd0, 8'h00, 8'h00},
    {3'd5, 8'hFF, 8'h00}, {3'd6, 8'h77, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd1, lo); rd(3'd2, hi); v = {hi, lo};
  endtask

  task automatic rld16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd3, lo); rd(3'd4, hi); v = {hi, lo};
  endtask

  task automatic setcnt(input logic [15:0] v);
    wr(3'd1, v[7:0]); wr(3'd2, v[15:8]);
  endtask

  task automatic pulse;
    @(negedge clk); cyc_en = 1'b1;
    @(negedge clk); cyc_en = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], b); chk("R2", {8'd0, b}, 16'd0);
    end
    chk("R2", {13'd0, ovf_flag, ext_flag, baud_tick}, 16'd0);

    // R1 register map from the vector table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], b);
      chk("R1", {8'd0, b}, {8'd0, VEC[i][7:0]});
    end

    // R3 timer counting
    wr(3'd0, 8'h04); setcnt(16'h0010);
    repeat (3) pulse();
    repeat (4) @(negedge clk);
    rd16(v); chk("R3", v, 16'h0013);

    // R4 event counting
    wr(3'd0, 8'h06); setcnt(16'h0000);
    ext_cnt = 1'b1; pulse();
    ext_cnt = 1'b0; pulse();
    pulse();
    ext_cnt = 1'b1; @(negedge clk); ext_cnt = 1'b0; pulse();
    rd16(v); chk("R4", v, 16'h0001);
    ext_cnt = 1'b1; pulse(); ext_cnt = 1'b0; pulse();
    rd16(v); chk("R4", v, 16'h0002);

    // R5 capture mode wrap to zero
    wr(3'd0, 8'h05); setcnt(16'hFFFF); pulse();
    rd16(v); chk("R5", v, 16'h0000);
    rd(3'd0, b); chk("R5", {8'd0, b}, 16'h0085);

    // R6 capture on trigger fall
    wr(3'd0, 8'h0D); setcnt(16'h1234);
    @(negedge clk); ext_trig = 1'b0; @(negedge clk); ext_trig = 1'b1;
    rld16(v); chk("R6", v, 16'h1234);
    chk("R6", {15'd0, ext_flag}, 16'd1);
    wr(3'd0, 8'h05); setcnt(16'h2222);
    @(negedge clk); ext_trig = 1'b0; @(negedge clk); ext_trig = 1'b1;
    rld16(v); chk("R6", v, 16'h1234);
    chk("R6", {15'd0, ext_flag}, 16'd0);

    // R7 auto-reload up, R10 flag kept
    wr(3'd0, 8'h04); wr(3'd3, 8'hCD); wr(3'd4, 8'hAB); setcnt(16'hFFFE);
    pulse(); chk("R7", {15'd0, ovf_flag}, 16'd0);
    pulse(); rd16(v); chk("R7", v, 16'hABCD);
    chk("R7", {15'd0, ovf_flag}, 16'd1);
    pulse(); repeat (3) @(negedge clk);
    chk("R10", {15'd0, ovf_flag}, 16'd1);
    wr(3'd0, 8'h04); chk("R10", {15'd0, ovf_flag}, 16'd0);

    // R8 down counting
    ext_trig = 1'b0;
    wr(3'd0, 8'h14); wr(3'd3, 8'h00); wr(3'd4, 8'h01); setcnt(16'h0001);
    pulse(); rd16(v); chk("R8", v, 16'h0000);
    rd(3'd5, b); chk("R8", {8'd0, b}, 16'h0000);
    pulse(); rd16(v); chk("R8", v, 16'h0100);
    chk("R8", {15'd0, ovf_flag}, 16'd1);
    rd(3'd5, b); chk("R8", {8'd0, b}, 16'h0001);
    ext_trig = 1'b1; pulse(); rd16(v); chk("R8", v, 16'h0101);

    // R9 baud mode
    wr(3'd0, 8'h24); wr(3'd3, 8'hFE); wr(3'd4, 8'hFF); setcnt(16'hFFFF);
    pulse(); #1 chk("R9", {15'd0, baud_tick}, 16'd1);
    @(posedge clk); #1 chk("R9", {15'd0, baud_tick}, 16'd0);
    rd16(v); chk("R9", v, 16'hFFFE);
    chk("R9", {15'd0, ovf_flag}, 16'd0);

    // R11 count write beats step; control write beats flag set
    wr(3'd0, 8'h04); setcnt(16'h0100);
    @(negedge clk); we = 1'b1; addr = 3'd1; wdata = 8'h55; cyc_en = 1'b1;
    @(negedge clk); we = 1'b0; cyc_en = 1'b0;
    rd16(v); chk("R11", v, 16'h0155);
    setcnt(16'hFFFF);
    @(negedge clk); we = 1'b1; addr = 3'd0; wdata = 8'h04; cyc_en = 1'b1;
    @(negedge clk); we = 1'b0; cyc_en = 1'b0;
    chk("R11", {15'd0, ovf_flag}, 16'd0);

    // R12 stopped counter holds
    wr(3'd0, 8'h00); setcnt(16'h0007);
    pulse(); ext_cnt = 1'b1; pulse(); ext_cnt = 1'b0; pulse();
    rd16(v); chk("R12", v, 16'h0007);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule